// File: doc/BRIEF.md
# Multiport Synchronous Memory

This block is a word-organised storage array that several ports reach at the same time. There are three kinds of port: read-write, read-only and write-only. A parameter sets how many of each kind there are. Every port has an active-low select and an address. A port that can write also has write data. A read-write port has an active-low write enable as well. All ports share one clock.

Each port takes its request on the rising edge. The answer comes during the low half of that same clock cycle. A read that meets a write to the same word on another port in the same cycle sees the word being written, not the old contents.

Writers are numbered with the read-write ports first and the write-only ports after them. When several writers hit one word in one cycle, the lowest-numbered writer wins and the simulation prints a warning. Readers are numbered the same way, with the read-only ports after the read-write ports.

The storage is never cleared, and it keeps its contents through a reset. The reset input is asserted asynchronously and released on the clock through a two-stage synchroniser. Each count of port kinds must be at least one.

Top module: `mp_sram`

## Requirements
- R1: Select, write enable, address and write data of every port are taken on the rising clock edge. Changes to them later in the same cycle do not alter that cycle's access.
- R2: Read data of a cycle appears on the data output after that cycle's falling edge. Until then the output keeps its previous value.
- R3: The number of read-write, read-only and write-only ports is set by parameters. Any read-capable port can read back a word written through any write-capable port.
- R4: A read of a word that another port writes in the same cycle returns the data being written in that cycle.
- R5: Writers are numbered with read-write ports first, then write-only ports. When two writers write the same word in one cycle, the word takes the data of the lowest-numbered writer, and a read of that word in that cycle returns the same data.
- R6: A port whose select is high (inactive) makes no access: it writes nothing, and its data output keeps its last value.
- R7: A read-write port that writes (select low, write enable low) does not read in that cycle. Its data output keeps its last value.
- R8: While reset is asserted, every data output is zero and no access takes place.
- R9: Memory contents are not cleared by reset. A word written before a reset reads back unchanged after it.
- R10: A word written in one cycle returns the written data on any later read, until it is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock. Requests are taken on the rising edge; reads resolve on the falling edge. |
| rst_n | input | 1 | Active-low reset. Asserted asynchronously, released synchronously. |
| rw_csb | input | NUM_RW | Active-low select, one bit per read-write port. |
| rw_web | input | NUM_RW | Active-low write enable, one bit per read-write port. |
| rw_addr | input | NUM_RW*ADDR_W | Word addresses of the read-write ports. Port i uses bits [i*ADDR_W +: ADDR_W]. |
| rw_din | input | NUM_RW*WORD_W | Write data of the read-write ports. |
| rw_dout | output | NUM_RW*WORD_W | Read data of the read-write ports. |
| ro_csb | input | NUM_RO | Active-low select, one bit per read-only port. |
| ro_addr | input | NUM_RO*ADDR_W | Word addresses of the read-only ports. |
| ro_dout | output | NUM_RO*WORD_W | Read data of the read-only ports. |
| wo_csb | input | NUM_WO | Active-low select, one bit per write-only port. A selected write-only port always writes. |
| wo_addr | input | NUM_WO*ADDR_W | Word addresses of the write-only ports. |
| wo_din | input | NUM_WO*WORD_W | Write data of the write-only ports. |

## Verification
A request presented before rising edge N is resolved at falling edge N. Its read data is therefore due half a cycle after capture. The bench drives new inputs just after a falling edge, updates its reference model at the rising edge, and compares every read output one time unit after the next falling edge. One directed cycle also samples just after the rising edge, to confirm the output still holds the previous value, and changes the address there to confirm the capture. The reference model keeps a validity flag per word, so reads of words that were never written are not compared. The reset checks are taken while reset is held, when every output must be zero.

// File: rtl/mp_sram_pkg.sv
package mp_sram_pkg;
  // kind of an access port; picks how its write enable is derived
  typedef enum logic [1:0] {
    PK_RW = 2'd0,
    PK_RO = 2'd1,
    PK_WO = 2'd2
  } port_kind_e;
endpackage

// File: rtl/mp_sram_inreg.sv
module mp_sram_inreg
  import mp_sram_pkg::*;
#(
  parameter port_kind_e KIND = PK_RW,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csb_i,
  input  logic          web_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  output logic          rd_en_o,
  output logic          wr_en_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] din_o
);
  logic          cs_d, cs_q, we_d, we_q, cap_en;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] din_q;

  generate
    if (KIND == PK_RW) begin : g_we_rw
      assign we_d = !web_i;
    end else if (KIND == PK_RO) begin : g_we_ro
      assign we_d = 1'b0;
    end else begin : g_we_wo
      assign we_d = 1'b1;
    end
  endgenerate

  always_comb begin
    cs_d   = !csb_i;
    cap_en = !csb_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      we_q <= 1'b0;
    end else begin
      cs_q <= cs_d;
      we_q <= we_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q <= addr_i;
      din_q  <= din_i;
    end
  end

  assign rd_en_o = cs_q && !we_q;
  assign wr_en_o = cs_q && we_q;
  assign addr_o  = addr_q;
  assign din_o   = din_q;

  // R8
  rst_noacc_chk: assert property (@(posedge clk) !rst_n |-> (!rd_en_o && !wr_en_o));
endmodule

// File: rtl/mp_sram_store.sv
module mp_sram_store #(
  parameter int NWR   = 2,
  parameter int NRD   = 2,
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NWR-1:0]           wr_en_i,
  input  logic [NWR-1:0][AW-1:0]   wr_addr_i,
  input  logic [NWR-1:0][DW-1:0]   wr_data_i,
  input  logic [NRD-1:0][AW-1:0]   rd_addr_i,
  output logic [NRD-1:0][DW-1:0]   rd_data_o
);
  logic [DW-1:0] mem [DEPTH];

  // highest index applied first so the lowest-numbered writer lands last
  always_ff @(negedge clk) begin
    for (int i = NWR - 1; i >= 0; i--) begin
      if (wr_en_i[i]) begin
        mem[wr_addr_i[i]] <= wr_data_i[i];
      end
    end
  end

  generate
    for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_data_o[r] = mem[rd_addr_i[r]];
    end
  endgenerate

  always @(negedge clk) begin
    for (int i = 0; i < NWR; i++) begin
      for (int j = i + 1; j < NWR; j++) begin
        if (rst_n && wr_en_i[i] && wr_en_i[j] && (wr_addr_i[i] == wr_addr_i[j])) begin
          $warning("writers %0d and %0d collide on word %0d; writer %0d kept", i, j, wr_addr_i[i], i);
        end
      end
    end
  end

  // R5
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i[0] |-> (mem[wr_addr_i[0]] == wr_data_i[0]));
endmodule

// File: rtl/mp_sram_rdport.sv
module mp_sram_rdport #(
  parameter int NWR = 2,
  parameter int DW  = 8,
  parameter int AW  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en_i,
  input  logic [AW-1:0]          rd_addr_i,
  input  logic [DW-1:0]          mem_data_i,
  input  logic [NWR-1:0]         wr_en_i,
  input  logic [NWR-1:0][AW-1:0] wr_addr_i,
  input  logic [NWR-1:0][DW-1:0] wr_data_i,
  output logic [DW-1:0]          dout_o
);
  logic          byp_hit;
  logic [DW-1:0] byp_data, dout_d, dout_q;

  always_comb begin
    byp_hit  = 1'b0;
    byp_data = '0;
    for (int i = NWR - 1; i >= 0; i--) begin
      if (wr_en_i[i] && (wr_addr_i[i] == rd_addr_i)) begin
        byp_hit  = 1'b1;
        byp_data = wr_data_i[i];
      end
    end
    dout_d = rd_en_i ? (byp_hit ? byp_data : mem_data_i) : dout_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else begin
      dout_q <= dout_d;
    end
  end

  assign dout_o = dout_q;

  // R6
  hold_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |-> $stable(dout_o));
  // R4
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && wr_en_i[0] && (wr_addr_i[0] == rd_addr_i)) |-> (dout_o == wr_data_i[0]));
endmodule

// File: rtl/mp_sram.sv
module mp_sram
  import mp_sram_pkg::*;
#(
  parameter int NUM_RW = 1,
  parameter int NUM_RO = 1,
  parameter int NUM_WO = 1,
  parameter int WORD_W = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_RW-1:0]        rw_csb,
  input  logic [NUM_RW-1:0]        rw_web,
  input  logic [NUM_RW*ADDR_W-1:0] rw_addr,
  input  logic [NUM_RW*WORD_W-1:0] rw_din,
  output logic [NUM_RW*WORD_W-1:0] rw_dout,
  input  logic [NUM_RO-1:0]        ro_csb,
  input  logic [NUM_RO*ADDR_W-1:0] ro_addr,
  output logic [NUM_RO*WORD_W-1:0] ro_dout,
  input  logic [NUM_WO-1:0]        wo_csb,
  input  logic [NUM_WO*ADDR_W-1:0] wo_addr,
  input  logic [NUM_WO*WORD_W-1:0] wo_din
);
  localparam int NWR = NUM_RW + NUM_WO;
  localparam int NRD = NUM_RW + NUM_RO;

  logic [1:0] rst_sync;
  logic       rst_s;

  logic [NWR-1:0]             wr_en;
  logic [NWR-1:0][ADDR_W-1:0] wr_addr;
  logic [NWR-1:0][WORD_W-1:0] wr_data;
  logic [NRD-1:0]             rd_en;
  logic [NRD-1:0][ADDR_W-1:0] rd_addr;
  logic [NRD-1:0][WORD_W-1:0] rd_mem;
  logic [NRD-1:0][WORD_W-1:0] rd_dout;
  logic [NUM_RW-1:0][ADDR_W-1:0] rw_a;
  logic [NUM_RO-1:0]             ro_wr_nc;
  logic [NUM_RO-1:0][WORD_W-1:0] ro_din_nc;
  logic [NUM_WO-1:0]             wo_rd_nc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_s = rst_sync[1];

  generate
    for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
      mp_sram_inreg #(.KIND(PK_RW), .AW(ADDR_W), .DW(WORD_W)) u_in (
        .clk(clk), .rst_n(rst_s), .csb_i(rw_csb[i]), .web_i(rw_web[i]),
        .addr_i(rw_addr[i*ADDR_W +: ADDR_W]), .din_i(rw_din[i*WORD_W +: WORD_W]),
        .rd_en_o(rd_en[i]), .wr_en_o(wr_en[i]), .addr_o(rw_a[i]), .din_o(wr_data[i]));
      assign wr_addr[i] = rw_a[i];
      assign rd_addr[i] = rw_a[i];
      assign rw_dout[i*WORD_W +: WORD_W] = rd_dout[i];
    end
    for (genvar i = 0; i < NUM_RO; i++) begin : g_ro
      mp_sram_inreg #(.KIND(PK_RO), .AW(ADDR_W), .DW(WORD_W)) u_in (
        .clk(clk), .rst_n(rst_s), .csb_i(ro_csb[i]), .web_i(1'b1),
        .addr_i(ro_addr[i*ADDR_W +: ADDR_W]), .din_i('0),
        .rd_en_o(rd_en[NUM_RW+i]), .wr_en_o(ro_wr_nc[i]),
        .addr_o(rd_addr[NUM_RW+i]), .din_o(ro_din_nc[i]));
      assign ro_dout[i*WORD_W +: WORD_W] = rd_dout[NUM_RW+i];
    end
    for (genvar i = 0; i < NUM_WO; i++) begin : g_wo
      mp_sram_inreg #(.KIND(PK_WO), .AW(ADDR_W), .DW(WORD_W)) u_in (
        .clk(clk), .rst_n(rst_s), .csb_i(wo_csb[i]), .web_i(1'b0),
        .addr_i(wo_addr[i*ADDR_W +: ADDR_W]), .din_i(wo_din[i*WORD_W +: WORD_W]),
        .rd_en_o(wo_rd_nc[i]), .wr_en_o(wr_en[NUM_RW+i]),
        .addr_o(wr_addr[NUM_RW+i]), .din_o(wr_data[NUM_RW+i]));
    end
  endgenerate

  mp_sram_store #(.NWR(NWR), .NRD(NRD), .DW(WORD_W), .DEPTH(DEPTH), .AW(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_s), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_mem));

  generate
    for (genvar r = 0; r < NRD; r++) begin : g_rdp
      mp_sram_rdport #(.NWR(NWR), .DW(WORD_W), .AW(ADDR_W)) u_rdp (
        .clk(clk), .rst_n(rst_s), .rd_en_i(rd_en[r]), .rd_addr_i(rd_addr[r]),
        .mem_data_i(rd_mem[r]), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .dout_o(rd_dout[r]));
    end
  endgenerate
endmodule

// File: tb/mp_sram_tb.sv
module mp_sram_tb_top;
  localparam int PERIOD = 10;
  localparam int NRW = 1, NRO = 1, NWO = 1;
  localparam int DW = 8, DEPTH = 16, AW = 4;
  localparam int NWR = NRW + NWO, NRD = NRW + NRO;

  logic clk = 1'b0;
  logic rst_n;
  logic [NRW-1:0]    rw_csb, rw_web;
  logic [NRW*AW-1:0] rw_addr;
  logic [NRW*DW-1:0] rw_din, rw_dout;
  logic [NRO-1:0]    ro_csb;
  logic [NRO*AW-1:0] ro_addr;
  logic [NRO*DW-1:0] ro_dout;
  logic [NWO-1:0]    wo_csb;
  logic [NWO*AW-1:0] wo_addr;
  logic [NWO*DW-1:0] wo_din;

  int checks = 0;
  int bad = 0;

  logic [DW-1:0] memv [DEPTH];
  bit            memok [DEPTH];
  logic [DW-1:0] expd [NRD];
  bit            expok [NRD];
  bit            s_wen [NWR];
  int            s_wad [NWR];
  logic [DW-1:0] s_wdt [NWR];
  bit            s_ren [NRD];
  int            s_rad [NRD];

  always #(PERIOD/2) clk = ~clk;

  mp_sram #(.NUM_RW(NRW), .NUM_RO(NRO), .NUM_WO(NWO), .WORD_W(DW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .rw_csb(rw_csb), .rw_web(rw_web), .rw_addr(rw_addr),
    .rw_din(rw_din), .rw_dout(rw_dout), .ro_csb(ro_csb), .ro_addr(ro_addr),
    .ro_dout(ro_dout), .wo_csb(wo_csb), .wo_addr(wo_addr), .wo_din(wo_din));

  function automatic logic [DW-1:0] rd_out(input int r);
    if (r < NRW) return rw_dout[r*DW +: DW];
    return ro_dout[(r-NRW)*DW +: DW];
  endfunction

  task automatic idle();
    rw_csb = '1; rw_web = '1; ro_csb = '1; wo_csb = '1;
  endtask

  task automatic snap();
    for (int i = 0; i < NWR; i++) begin
      if (i < NRW) begin
        s_wen[i] = !rw_csb[i] && !rw_web[i];
        s_wad[i] = int'(rw_addr[i*AW +: AW]);
        s_wdt[i] = rw_din[i*DW +: DW];
      end else begin
        s_wen[i] = !wo_csb[i-NRW];
        s_wad[i] = int'(wo_addr[(i-NRW)*AW +: AW]);
        s_wdt[i] = wo_din[(i-NRW)*DW +: DW];
      end
    end
    for (int r = 0; r < NRD; r++) begin
      if (r < NRW) begin
        s_ren[r] = !rw_csb[r] && rw_web[r];
        s_rad[r] = int'(rw_addr[r*AW +: AW]);
      end else begin
        s_ren[r] = !ro_csb[r-NRW];
        s_rad[r] = int'(ro_addr[(r-NRW)*AW +: AW]);
      end
    end
  endtask

  task automatic model();
    for (int r = 0; r < NRD; r++) begin
      if (s_ren[r]) begin
        bit hit = 0;
        for (int i = 0; i < NWR; i++) begin
          if (!hit && s_wen[i] && s_wad[i] == s_rad[r]) begin
            hit = 1; expd[r] = s_wdt[i]; expok[r] = 1;
          end
        end
        if (!hit) begin expd[r] = memv[s_rad[r]]; expok[r] = memok[s_rad[r]]; end
      end
    end
    for (int i = NWR - 1; i >= 0; i--) begin
      if (s_wen[i]) begin memv[s_wad[i]] = s_wdt[i]; memok[s_wad[i]] = 1; end
    end
  endtask

  task automatic compare(input string tag);
    for (int r = 0; r < NRD; r++) begin
      if (expok[r]) begin
        checks++;
        if (rd_out(r) !== expd[r]) begin
          bad++;
          $display("FAIL %s reader %0d: got %h expected %h", tag, r, rd_out(r), expd[r]);
        end
      end
    end
  endtask

  // one access cycle; late=1 also checks R2 hold and R1 capture
  task automatic step(input string tag, input bit late = 0);
    @(posedge clk);
    snap();
    if (late) begin
      #1;
      compare("R2 before falling edge");
      ro_addr = ~ro_addr; rw_addr = ~rw_addr; rw_web = ~rw_web;
    end
    model();
    @(negedge clk); #1;
    compare(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle();
    for (int r = 0; r < NRD; r++) begin expd[r] = '0; expok[r] = 1; end
    repeat (2) @(negedge clk);
    #1 compare("R8");
    rst_n = 1'b1;
    repeat (3) step("R8");
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) memok[a] = 0;
    rw_addr = '0; rw_din = '0; ro_addr = '0; wo_addr = '0; wo_din = '0;
    idle();
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    do_reset();

    // fill through the write-only port, read through both readers
    for (int a = 0; a < DEPTH; a++) begin
      idle(); wo_csb = '0; wo_addr = AW'(a); wo_din = DW'(a * 17) ^ 8'h5A;
      step("R10");
    end
    for (int a = 0; a < DEPTH; a++) begin
      idle(); ro_csb = '0; ro_addr = AW'(a);
      rw_csb = '0; rw_web = '1; rw_addr = AW'(DEPTH - 1 - a);
      step("R3");
    end

    // two writers on one word: read-write port (writer 0) wins
    idle(); rw_csb = '0; rw_web = '0; rw_addr = 4'd3; rw_din = 8'hAA;
    wo_csb = '0; wo_addr = 4'd3; wo_din = 8'h55; ro_csb = '0; ro_addr = 4'd3;
    step("R5");
    idle(); ro_csb = '0; ro_addr = 4'd3; step("R5");

    // same-cycle write and reads of one word
    idle(); wo_csb = '0; wo_addr = 4'd5; wo_din = 8'h3C;
    ro_csb = '0; ro_addr = 4'd5; rw_csb = '0; rw_web = '1; rw_addr = 4'd5;
    step("R4");

    // deselected ports: outputs hold, write ignored
    idle(); rw_addr = 4'd9; ro_addr = 4'd9; wo_addr = 4'd9; wo_din = 8'hFF;
    step("R6");
    idle(); ro_csb = '0; ro_addr = 4'd9; step("R6");

    // read-write port writing does not read
    idle(); rw_csb = '0; rw_web = '0; rw_addr = 4'd7; rw_din = 8'hC3;
    step("R7");
    idle(); ro_csb = '0; ro_addr = 4'd7; step("R7");

    // capture on rising edge and late output
    idle(); ro_csb = '0; ro_addr = 4'd2; rw_csb = '0; rw_web = '1; rw_addr = 4'd12;
    step("R1", 1);

    // contents survive a reset
    do_reset();
    for (int a = 0; a < 4; a++) begin
      idle(); ro_csb = '0; ro_addr = AW'(a); rw_csb = '0; rw_web = '1; rw_addr = AW'(a + 8);
      step("R9");
    end

    // mixed traffic on a narrow address range
    for (int n = 0; n < 3000; n++) begin
      rw_csb = 1'($urandom); rw_web = 1'($urandom); rw_addr = AW'($urandom % 4);
      rw_din = DW'($urandom); ro_csb = 1'($urandom); ro_addr = AW'($urandom % 4);
      wo_csb = 1'($urandom); wo_addr = AW'($urandom % 4); wo_din = DW'($urandom);
      step("R4 R5 R10 mixed");
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule